// File: doc/BRIEF.md
# Transmit Queue Readiness and Priority Grant

This block decides when each of four transmit queues may be offered to the MAC transmitter, and which one gets it. The queues carry the numbers 2 to 5. For every queue the block keeps two counters. The first holds the number of data blocks the queue currently stores. The second holds the number of complete frames, meaning frames whose end marker has been written. Both counters move on single-cycle pulses from the queue writer (the host side) and from the queue reader (the transmitter side).

A 2-bit readiness policy and a block threshold are set per queue. From these and the two counts, the block derives a per-queue ready flag. The same threshold also drives a sticky refill interrupt, which prompts the host to add more data. Whenever the transmitter reports idle and no grant is outstanding, the block grants the lowest-numbered ready queue. It holds that grant until the reader reports that the frame has finished. Memory allocation and data movement happen elsewhere. This block only sees the counting pulses.

Top module: `txq_ready_arb`

## Requirements
- R1: The block count of a queue rises by one on an increment pulse and falls by one on a decrement pulse. When both pulses arrive in the same cycle, the count is unchanged. A decrement at zero leaves the count at zero.
- R2: With policy code 2'b00, a queue is ready exactly when its block count is at least one.
- R3: With policy code 2'b01, a queue is ready exactly when its block count is strictly greater than its threshold. Stored complete frames do not affect this.
- R4: With policy code 2'b10, a queue is ready exactly when it holds at least one complete frame, whatever its block count.
- R5: With policy code 2'b11, a queue is ready when it holds a complete frame or when its block count is strictly greater than its threshold.
- R6: A queue's refill interrupt sets on the cycle its block count drops from at-or-above the threshold to below it. It stays set until a clear pulse arrives, and a set in the same cycle wins over the clear. Sitting below the threshold, including right after reset, never sets it.
- R7: When `tx_idle` is high and no grant is held, the block grants the lowest-numbered ready queue on the next clock edge. `gnt_queue` carries the queue number (2 to 5) and `gnt_onehot` has bit 0 for queue 2. While `tx_idle` is low, no grant is issued.
- R8: A grant and its queue number stay unchanged until `tx_frame_done` is pulsed, even if other queues become ready. The grant drops on the edge that follows `tx_frame_done`.
- R9: A queue holds at most 125 complete frames. `sof_ok` for a queue is low while its frame count is 125. A further frame-end pulse at 125 is ignored.
- R10: After reset, all counts are zero, no queue is ready, no interrupt is set, no grant is held, and every `sof_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_mode | input | 2*NQ | Readiness policy per queue, 2 bits each, queue 2 in bits [1:0] |
| q_thresh | input | BLK_W*NQ | Block threshold per queue |
| blk_inc | input | NQ | Block added pulse per queue |
| blk_dec | input | NQ | Block removed pulse per queue |
| frm_in | input | NQ | Complete frame stored pulse (end marker written) |
| frm_out | input | NQ | Complete frame consumed pulse |
| irq_clr | input | NQ | Clear pulse for the refill interrupt |
| tx_idle | input | 1 | Transmitter idle and able to accept a queue |
| tx_frame_done | input | 1 | Transmitter finished the granted frame |
| sof_ok | output | NQ | Queue may accept a new frame start |
| q_ready | output | NQ | Per-queue ready flag |
| q_blocks | output | BLK_W*NQ | Per-queue block count |
| q_frames | output | FRM_W*NQ | Per-queue complete-frame count |
| low_irq | output | NQ | Sticky refill interrupt per queue |
| gnt_valid | output | 1 | A grant is held |
| gnt_onehot | output | NQ | One-hot granted queue |
| gnt_queue | output | QN_W | Granted queue number |

## Verification
The bench aims at the threshold edge under policy 01. A count equal to the threshold must read not ready, and a design using `>=` would flag it ready. It also drives blocks down past the threshold several times. A level-sensitive interrupt would fire straight out of reset, and a non-sticky one would vanish one step later. For arbitration, it makes a lower-numbered queue ready in the middle of a frame. A design that re-arbitrates each cycle would move the grant away from queue 3 before the frame ends. Finally, the bench fills a queue to exactly 125 frames and sends one more frame end. An off-by-one limit shows up as a wrong `sof_ok` or a count of 126.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [1:0] {
    RDY_ANY    = 2'b00,
    RDY_THRESH = 2'b01,
    RDY_FRAME  = 2'b10,
    RDY_EITHER = 2'b11
  } rdy_mode_e;

  // Readiness policy evaluation from pre-compared conditions.
  function automatic logic ready_eval(input rdy_mode_e m, input logic nonempty,
                                      input logic above, input logic has_frame);
    logic r;
    case (m)
      RDY_ANY:    r = nonempty;
      RDY_THRESH: r = above;
      RDY_FRAME:  r = has_frame;
      default:    r = has_frame | above;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/txq_updown.sv
module txq_updown #(
  parameter int W   = 8,
  parameter int MAX = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         full
);
  localparam logic [W-1:0] TOP = W'(MAX);

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic up,
                                        input logic dn);
    logic [W-1:0] n;
    n = c;
    if (up && !dn && c != TOP) n = c + 1'b1;
    if (dn && !up && c != '0)  n = c - 1'b1;
    return n;
  endfunction

  assign cnt_nxt = step(cnt, inc, dec);
  assign full    = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R1: simultaneous pulses cancel
  a_r1_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));
  // R1: single increment below the top steps by one
  a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
  // R1: floor at zero
  a_r1_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt == '0) |=> (cnt == '0));
  // R9: never beyond the limit
  a_r9_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);

endmodule

// File: rtl/txq_qstate.sv
module txq_qstate
  import txq_pkg::*;
#(
  parameter int BLK_W   = 8,
  parameter int FRM_MAX = 125,
  parameter int FRM_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [BLK_W-1:0] thr,
  input  logic             blk_inc,
  input  logic             blk_dec,
  input  logic             frm_in,
  input  logic             frm_out,
  input  logic             irq_clr,
  output logic [BLK_W-1:0] blocks,
  output logic [FRM_W-1:0] frames,
  output logic             ready,
  output logic             low_irq,
  output logic             sof_ok
);
  logic [BLK_W-1:0] blk_nxt;
  logic [FRM_W-1:0] frm_nxt;
  logic             blk_full, frm_full;
  logic             thr_fall_evt;

  txq_updown #(.W(BLK_W), .MAX((1 << BLK_W) - 1)) u_blk (
    .clk(clk), .rst_n(rst_n), .inc(blk_inc), .dec(blk_dec),
    .cnt(blocks), .cnt_nxt(blk_nxt), .full(blk_full));

  txq_updown #(.W(FRM_W), .MAX(FRM_MAX)) u_frm (
    .clk(clk), .rst_n(rst_n), .inc(frm_in), .dec(frm_out),
    .cnt(frames), .cnt_nxt(frm_nxt), .full(frm_full));

  assign sof_ok = !frm_full;
  assign ready  = ready_eval(rdy_mode_e'(mode), blocks != '0, blocks > thr,
                             frames != '0);

  // Downward crossing of the threshold, seen on the edge that makes it.
  assign thr_fall_evt = (blocks >= thr) && (blk_nxt < thr);

  always_ff @(posedge clk) begin
    if (!rst_n)            low_irq <= 1'b0;
    else if (thr_fall_evt) low_irq <= 1'b1;
    else if (irq_clr)      low_irq <= 1'b0;
  end

  // R6: sticky until cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (low_irq && !irq_clr) |=> low_irq);
  // R6: a new interrupt needs a downward crossing
  a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_irq) |-> ($past(blocks) >= $past(thr)) && (blocks < $past(thr)));
  // R2: an empty queue under policy 00 is never ready
  a_r2_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && blocks == '0) |-> !ready);
  // R9: refusal tracks the frame limit
  a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (frames == FRM_W'(FRM_MAX)) |-> !sof_ok);

  logic unused_ok;
  assign unused_ok = &{1'b0, blk_full, frm_nxt};

endmodule

// File: rtl/txq_prio.sv
module txq_prio #(
  parameter int NQ   = 4,
  parameter int BASE = 2,
  parameter int QN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NQ-1:0]   ready,
  input  logic            tx_idle,
  input  logic            tx_frame_done,
  output logic            gnt_valid,
  output logic [NQ-1:0]   gnt_onehot,
  output logic [QN_W-1:0] gnt_queue
);
  localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1;

  logic [IDX_W-1:0] pick_idx, gnt_idx;
  logic             pick_any;
  logic             grant_evt, release_evt;

  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (ready[i]) begin
        pick_idx = IDX_W'(i);
        pick_any = 1'b1;
      end
    end
  end

  assign grant_evt   = !gnt_valid && tx_idle && pick_any;
  assign release_evt = gnt_valid && tx_frame_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
    end else if (grant_evt) begin
      gnt_valid <= 1'b1;
      gnt_idx   <= pick_idx;
    end else if (release_evt) begin
      gnt_valid <= 1'b0;
    end
  end

  always_comb begin
    gnt_onehot = '0;
    if (gnt_valid) gnt_onehot[gnt_idx] = 1'b1;
  end
  assign gnt_queue = QN_W'(BASE) + QN_W'(gnt_idx);

  // R7: at most one queue granted
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_onehot));
  // R7: the lowest queue wins when ready at grant time
  a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && tx_idle && ready[0]) |=> gnt_onehot[0]);
  // R7: grants only start while the transmitter is idle
  a_r7_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> $past(tx_idle));
  // R8: grant held until frame done
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !tx_frame_done) |=> gnt_valid && $stable(gnt_queue));

endmodule

// File: rtl/txq_ready_arb.sv
module txq_ready_arb #(
  parameter int NQ      = 4,
  parameter int BASE    = 2,
  parameter int BLK_W   = 8,
  parameter int FRM_MAX = 125,
  localparam int FRM_W  = $clog2(FRM_MAX + 1),
  localparam int QN_W   = $clog2(BASE + NQ)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NQ-1:0]     q_mode,
  input  logic [BLK_W*NQ-1:0] q_thresh,
  input  logic [NQ-1:0]       blk_inc,
  input  logic [NQ-1:0]       blk_dec,
  input  logic [NQ-1:0]       frm_in,
  input  logic [NQ-1:0]       frm_out,
  input  logic [NQ-1:0]       irq_clr,
  input  logic                tx_idle,
  input  logic                tx_frame_done,
  output logic [NQ-1:0]       sof_ok,
  output logic [NQ-1:0]       q_ready,
  output logic [BLK_W*NQ-1:0] q_blocks,
  output logic [FRM_W*NQ-1:0] q_frames,
  output logic [NQ-1:0]       low_irq,
  output logic                gnt_valid,
  output logic [NQ-1:0]       gnt_onehot,
  output logic [QN_W-1:0]     gnt_queue
);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    txq_qstate #(.BLK_W(BLK_W), .FRM_MAX(FRM_MAX), .FRM_W(FRM_W)) u_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (q_mode[2*q +: 2]),
      .thr     (q_thresh[BLK_W*q +: BLK_W]),
      .blk_inc (blk_inc[q]),
      .blk_dec (blk_dec[q]),
      .frm_in  (frm_in[q]),
      .frm_out (frm_out[q]),
      .irq_clr (irq_clr[q]),
      .blocks  (q_blocks[BLK_W*q +: BLK_W]),
      .frames  (q_frames[FRM_W*q +: FRM_W]),
      .ready   (q_ready[q]),
      .low_irq (low_irq[q]),
      .sof_ok  (sof_ok[q])
    );
  end

  txq_prio #(.NQ(NQ), .BASE(BASE), .QN_W(QN_W)) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready         (q_ready),
    .tx_idle       (tx_idle),
    .tx_frame_done (tx_frame_done),
    .gnt_valid     (gnt_valid),
    .gnt_onehot    (gnt_onehot),
    .gnt_queue     (gnt_queue)
  );

endmodule

// File: tb/txq_ready_arb_test.sv
`timescale 1ns/1ps
module txq_ready_arb_test;
  localparam int NQ = 4;
  localparam int BW = 8;
  localparam int FW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*NQ-1:0]  q_mode = '0;
  logic [BW*NQ-1:0] q_thresh = '0;
  logic [NQ-1:0] blk_inc = '0, blk_dec = '0, frm_in = '0, frm_out = '0, irq_clr = '0;
  logic tx_idle = 1'b0, tx_frame_done = 1'b0;
  logic [NQ-1:0] sof_ok, q_ready, low_irq, gnt_onehot;
  logic [BW*NQ-1:0] q_blocks;
  logic [FW*NQ-1:0] q_frames;
  logic gnt_valid;
  logic [2:0] gnt_queue;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  txq_ready_arb uut (.*);

  // {mode[1:0], thr[7:0], blocks[7:0], frames[7:0], expected}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {2'b00, 8'd5, 8'd0, 8'd0, 1'b0},  // R2
    {2'b00, 8'd5, 8'd1, 8'd0, 1'b1},  // R2
    {2'b01, 8'd3, 8'd3, 8'd0, 1'b0},  // R3 equal is not above
    {2'b01, 8'd3, 8'd4, 8'd0, 1'b1},  // R3
    {2'b01, 8'd0, 8'd1, 8'd0, 1'b1},  // R3
    {2'b01, 8'd3, 8'd0, 8'd2, 1'b0},  // R3 frames ignored
    {2'b10, 8'd2, 8'd6, 8'd0, 1'b0},  // R4
    {2'b10, 8'd2, 8'd1, 8'd1, 1'b1},  // R4
    {2'b10, 8'd0, 8'd0, 8'd1, 1'b1},  // R4
    {2'b11, 8'd4, 8'd2, 8'd1, 1'b1},  // R5
    {2'b11, 8'd4, 8'd4, 8'd0, 1'b0},  // R5
    {2'b11, 8'd4, 8'd5, 8'd0, 1'b1}   // R5
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  // kind: 0 blk_inc, 1 blk_dec, 2 frm_in, 3 frm_out, 4 irq_clr, 5 blk inc+dec
  task automatic pulse(input int q, input int kind);
    case (kind)
      0: blk_inc[q] = 1'b1;
      1: blk_dec[q] = 1'b1;
      2: frm_in[q]  = 1'b1;
      3: frm_out[q] = 1'b1;
      4: irq_clr[q] = 1'b1;
      default: begin blk_inc[q] = 1'b1; blk_dec[q] = 1'b1; end
    endcase
    tick();
    blk_inc = '0; blk_dec = '0; frm_in = '0; frm_out = '0; irq_clr = '0;
  endtask

  function automatic logic [31:0] blk_of(input int q);
    return 32'(q_blocks[BW*q +: BW]);
  endfunction
  function automatic logic [31:0] frm_of(input int q);
    return 32'(q_frames[FW*q +: FW]);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    check(32'(q_blocks), 0, "R10 blocks");
    check(32'(q_frames), 0, "R10 frames");
    check(32'(q_ready), 0, "R10 ready");
    check(32'(low_irq), 0, "R10 irq (R6 no irq below thr at reset)");
    check(32'(gnt_valid), 0, "R10 grant");
    check(32'(sof_ok), 4'hF, "R10 sof_ok");

    // Policy table, R2..R5
    for (int i = 0; i < NV; i++) begin
      int q;
      q = i % NQ;
      q_mode = '0; q_thresh = '0;
      q_mode[2*q +: 2]    = VEC[i][26:25];
      q_thresh[BW*q +: BW] = VEC[i][24:17];
      do_reset();
      for (int b = 0; b < int'(VEC[i][16:9]); b++) pulse(q, 0);
      for (int f = 0; f < int'(VEC[i][8:1]); f++) pulse(q, 2);
      check(32'(q_ready[q]), 32'(VEC[i][0]), $sformatf("R2-5 vector %0d", i));
    end

    // R1 counting
    q_mode = '0; q_thresh = '0;
    do_reset();
    pulse(0, 0); pulse(0, 0); pulse(0, 0);
    check(blk_of(0), 3, "R1 three increments");
    pulse(0, 5);
    check(blk_of(0), 3, "R1 inc and dec together");
    pulse(0, 1);
    check(blk_of(0), 2, "R1 decrement");
    pulse(0, 1); pulse(0, 1); pulse(0, 1);
    check(blk_of(0), 0, "R1 floor at zero");

    // R6 refill interrupt on queue index 1, threshold 3
    q_thresh[BW*1 +: BW] = 8'd3;
    do_reset();
    check(32'(low_irq[1]), 0, "R6 not set from reset");
    for (int b = 0; b < 4; b++) pulse(1, 0);
    check(32'(low_irq[1]), 0, "R6 rising count no irq");
    pulse(1, 1);
    check(32'(low_irq[1]), 0, "R6 equal to thr no irq");
    pulse(1, 1);
    check(32'(low_irq[1]), 1, "R6 drop below sets");
    pulse(1, 1);
    check(32'(low_irq[1]), 1, "R6 sticky");
    pulse(1, 4);
    check(32'(low_irq[1]), 0, "R6 clear");
    pulse(1, 1);
    check(32'(low_irq[1]), 0, "R6 staying below does not reset");
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    blk_dec[1] = 1'b1; irq_clr[1] = 1'b1;
    tick();
    blk_dec = '0; irq_clr = '0;
    check(32'(low_irq[1]), 1, "R6 set wins over clear");

    // R7 / R8 arbitration
    q_thresh = '0; q_mode = '0;
    do_reset();
    pulse(1, 0); pulse(2, 0);
    tick();
    check(32'(gnt_valid), 0, "R7 no grant while busy tx");
    tx_idle = 1'b1;
    tick();
    check(32'(gnt_queue), 3, "R7 lowest ready queue 3");
    check(32'(gnt_onehot), 4'b0010, "R7 onehot");
    pulse(0, 0);
    tick();
    check(32'(gnt_queue), 3, "R8 held despite queue 2 ready");
    tx_frame_done = 1'b1;
    tick();
    tx_frame_done = 1'b0;
    check(32'(gnt_valid), 0, "R8 release on done");
    tick();
    check(32'(gnt_queue), 2, "R7 regrant to queue 2");
    check(32'(gnt_valid), 1, "R7 regrant valid");
    tx_idle = 1'b0;

    // R9 frame limit on queue index 3
    do_reset();
    for (int f = 0; f < 124; f++) pulse(3, 2);
    check(32'(sof_ok[3]), 1, "R9 accept at 124");
    pulse(3, 2);
    check(frm_of(3), 125, "R9 count 125");
    check(32'(sof_ok[3]), 0, "R9 refuse at 125");
    pulse(3, 2);
    check(frm_of(3), 125, "R9 extra end ignored");
    pulse(3, 3);
    check(32'(sof_ok[3]), 1, "R9 accept after consume");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule